// File: doc/BRIEF.md
# Fixed-Point Multiply-Add Lane

A single arithmetic lane for a vector machine that handles fixed-point elements of a parameterised width W, where W is 16, 32 or 64. The same structure serves every width. Each operation takes three W-bit sources (`a_i`, `b_i`, `c_i`), a shift amount and a 5-bit opcode. A new operation can be issued every cycle, and its result appears a fixed three cycles later together with a valid flag.

The multiply path works at full element precision. The multiplier takes one signed W/2-bit half of `a_i` and one of `b_i`. It scales the W-bit product right by a programmable amount with rounding. The opcode can then add the scaled product to `c_i` or subtract it from `c_i`, and the sum saturates to the signed W-bit range. Choosing the shift amount to match the operand format supports any binary-point position.

The same three stages also carry the other operations:
- saturating add and saturating subtract;
- a rounding right scale and a saturating left scale;
- a narrowing clamp that limits a value to an 8-, 16- or 32-bit signed range.

Top module: `fxp_mac_unit`

## Requirements
- R1: Opcode bit 3 chooses the multiplier half of `a_i` and bit 4 chooses the half of `b_i` (1 = bits [W-1:W/2], 0 = bits [W/2-1:0]). Each half is a signed W/2-bit value.
- R2: Kind 0 (opcode[2:0]=0, multiply) returns the product of the two halves, rounded and shifted right by `shamt_i`, saturated to W bits.
- R3: Rounding is half-up. For a shift s>0 the value plus 2^(s-1) is shifted arithmetically right by s. For s=0 the value passes unchanged.
- R4: Kind 1 returns sat(`c_i` + rounded product) and kind 2 returns sat(`c_i` − rounded product), using the same half selection and shift as R2.
- R5: Kind 3 returns sat(`a_i` + `b_i`) and kind 4 returns sat(`a_i` − `b_i`).
- R6: Kind 5 returns sat of `a_i` shifted right by `shamt_i` with R3 rounding. Kind 6 returns sat(`a_i` × 2^`shamt_i`).
- R7: Kind 7 clamps `a_i` to the signed range of 8<<`shamt_i[1:0]` bits. When that width is at least W, `a_i` passes unchanged and no saturation is flagged.
- R8: A W-bit saturation yields 2^(W-1)−1 or −2^(W-1). Any clamp raises `res_sat_o` alongside that result.
- R9: `sat_o` rises with the first result whose `res_sat_o` is 1 and stays high until reset.
- R10: An operation presented with `in_valid_i` before clock edge e appears with `out_valid_o` after edge e+2. Back-to-back issue is accepted, and `out_valid_o` is low in cycles with no result due.
- R11: While reset is active, `out_valid_o`, `result_o`, `res_sat_o` and `sat_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present on the inputs |
| op_i | input | 5 | [2:0] kind, [3] half of a, [4] half of b |
| a_i | input | W | First source |
| b_i | input | W | Second source |
| c_i | input | W | Accumulator source for kinds 1 and 2 |
| shamt_i | input | $clog2(W) | Shift amount; bits [1:0] pick the narrow width for kind 7 |
| out_valid_o | output | 1 | Result valid |
| result_o | output | W | Result |
| res_sat_o | output | 1 | Result was clamped |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
Two functions can act in the same cycle: rounding and saturation. In a right scale of the most positive value, or a multiply-add with an accumulator at the range limit, the rounding increment alone can push the sum past the limit. Directed cases place operands exactly at that limit, at one below it, and with a zero shift. The expected value, the per-result flag and the sticky flag are each compared against a wide-integer model. The sticky flag is also judged when a clamping result is followed immediately by non-clamping ones issued back to back.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [2:0] {
    K_MUL  = 3'd0,
    K_MACA = 3'd1,
    K_MACS = 3'd2,
    K_ADD  = 3'd3,
    K_SUB  = 3'd4,
    K_SHR  = 3'd5,
    K_SHL  = 3'd6,
    K_NAR  = 3'd7
  } kind_e;

  localparam int unsigned OP_W = 5;
  localparam int unsigned NAR_BASE = 8;
endpackage

// File: rtl/fxp_mul_stage.sv
module fxp_mul_stage
  import fxp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned H = W / 2,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                v_i,
  input  logic [OP_W-1:0]     op_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [W-1:0]        c_i,
  input  logic [SW-1:0]       sh_i,
  output logic                v_o,
  output kind_e               kind_o,
  output logic signed [W-1:0] prod_o,
  output logic [W-1:0]        a_o,
  output logic [W-1:0]        b_o,
  output logic [W-1:0]        c_o,
  output logic [SW-1:0]       sh_o
);
  logic signed [H-1:0] ha, hb;
  logic signed [W-1:0] prod;

  assign ha   = op_i[3] ? a_i[W-1:H] : a_i[H-1:0];
  assign hb   = op_i[4] ? b_i[W-1:H] : b_i[H-1:0];
  assign prod = ha * hb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      kind_o <= K_MUL;
      prod_o <= '0;
      a_o    <= '0;
      b_o    <= '0;
      c_o    <= '0;
      sh_o   <= '0;
    end else begin
      v_o    <= v_i;
      kind_o <= kind_e'(op_i[2:0]);
      prod_o <= prod;
      a_o    <= a_i;
      b_o    <= b_i;
      c_o    <= c_i;
      sh_o   <= sh_i;
    end
  end
endmodule

// File: rtl/fxp_scale_stage.sv
module fxp_scale_stage
  import fxp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W),
  localparam int unsigned XW = 2 * W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  kind_e                kind_i,
  input  logic signed [W-1:0]  prod_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  input  logic [W-1:0]         c_i,
  input  logic [SW-1:0]        sh_i,
  output logic                 v_o,
  output kind_e                kind_o,
  output logic signed [XW-1:0] pre_o,
  output logic signed [W-1:0]  base_o,
  output logic [SW-1:0]        sh_o
);
  localparam logic signed [XW-1:0] ONE = XW'(1);

  logic signed [XW-1:0] src, rnd, shl, pre;

  // source of the rounding shifter: product or raw a
  assign src = (kind_i == K_SHR) ? XW'($signed(a_i)) : XW'(prod_i);

  always_comb begin
    if (sh_i == '0) rnd = src;
    else            rnd = (src + (ONE <<< (sh_i - SW'(1)))) >>> sh_i;
  end

  assign shl = XW'($signed(a_i)) <<< sh_i;

  always_comb begin
    unique case (kind_i)
      K_MUL, K_MACA, K_MACS, K_SHR: pre = rnd;
      K_ADD, K_SUB:                 pre = XW'($signed(b_i));
      K_SHL:                        pre = shl;
      default:                      pre = XW'($signed(a_i));
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o    <= 1'b0;
      kind_o <= K_MUL;
      pre_o  <= '0;
      base_o <= '0;
      sh_o   <= '0;
    end else begin
      v_o    <= v_i;
      kind_o <= kind_i;
      pre_o  <= pre;
      base_o <= (kind_i == K_MACA || kind_i == K_MACS) ? $signed(c_i) : $signed(a_i);
      sh_o   <= sh_i;
    end
  end
endmodule

// File: rtl/fxp_sat_stage.sv
module fxp_sat_stage
  import fxp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W),
  localparam int unsigned XW = 2 * W,
  localparam int unsigned SUMW = XW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  kind_e                kind_i,
  input  logic signed [XW-1:0] pre_i,
  input  logic signed [W-1:0]  base_i,
  input  logic [SW-1:0]        sh_i,
  output logic                 v_o,
  output logic [W-1:0]         res_o,
  output logic                 res_sat_o,
  output logic                 sticky_o
);
  localparam logic signed [SUMW-1:0] ONE = SUMW'(1);

  logic signed [SUMW-1:0] sum, hi, lo, clamped;
  logic                   sat;
  int unsigned            lim, nbits;

  always_comb begin
    unique case (kind_i)
      K_MACA, K_ADD: sum = SUMW'(base_i) + SUMW'(pre_i);
      K_MACS, K_SUB: sum = SUMW'(base_i) - SUMW'(pre_i);
      default:       sum = SUMW'(pre_i);
    endcase
  end

  always_comb begin
    nbits = NAR_BASE << sh_i[1:0];
    if (kind_i == K_NAR && nbits < W) lim = nbits;
    else                              lim = W;
    hi = (ONE <<< (lim - 1)) - ONE;
    lo = -(ONE <<< (lim - 1));
    if (sum > hi) begin
      clamped = hi;
      sat     = 1'b1;
    end else if (sum < lo) begin
      clamped = lo;
      sat     = 1'b1;
    end else begin
      clamped = sum;
      sat     = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o       <= 1'b0;
      res_o     <= '0;
      res_sat_o <= 1'b0;
      sticky_o  <= 1'b0;
    end else begin
      v_o       <= v_i;
      res_o     <= clamped[W-1:0];
      res_sat_o <= v_i & sat;
      sticky_o  <= sticky_o | (v_i & sat);
    end
  end
endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit
  import fxp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W),
  localparam int unsigned XW = 2 * W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    c_i,
  input  logic [SW-1:0]   shamt_i,
  output logic            out_valid_o,
  output logic [W-1:0]    result_o,
  output logic            res_sat_o,
  output logic            sat_o
);
  logic                 v1, v2;
  kind_e                k1, k2;
  logic signed [W-1:0]  prod1;
  logic [W-1:0]         a1, b1, c1;
  logic [SW-1:0]        sh1, sh2;
  logic signed [XW-1:0] pre2;
  logic signed [W-1:0]  base2;

  fxp_mul_stage #(.W(W)) u_mul (
    .clk_i, .rst_ni,
    .v_i(in_valid_i), .op_i, .a_i, .b_i, .c_i, .sh_i(shamt_i),
    .v_o(v1), .kind_o(k1), .prod_o(prod1), .a_o(a1), .b_o(b1), .c_o(c1), .sh_o(sh1)
  );

  fxp_scale_stage #(.W(W)) u_scale (
    .clk_i, .rst_ni,
    .v_i(v1), .kind_i(k1), .prod_i(prod1), .a_i(a1), .b_i(b1), .c_i(c1), .sh_i(sh1),
    .v_o(v2), .kind_o(k2), .pre_o(pre2), .base_o(base2), .sh_o(sh2)
  );

  fxp_sat_stage #(.W(W)) u_sat (
    .clk_i, .rst_ni,
    .v_i(v2), .kind_i(k2), .pre_i(pre2), .base_i(base2), .sh_i(sh2),
    .v_o(out_valid_o), .res_o(result_o), .res_sat_o(res_sat_o), .sticky_o(sat_o)
  );
endmodule

// File: rtl/fxp_mac_unit_chk.sv
module fxp_mac_unit_chk
  import fxp_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [SW-1:0]   shamt_i,
  input logic            out_valid_o,
  input logic [W-1:0]    result_o,
  input logic            res_sat_o,
  input logic            sat_o
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [2:0]   vq;
  logic [2:0]   kq [3];
  logic [1:0]   nq [3];
  logic [1:0]   age;
  int unsigned  nb;
  logic signed [W:0] hi_n, lo_n, res_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vq  <= '0;
      age <= '0;
      for (int i = 0; i < 3; i++) begin
        kq[i] <= '0;
        nq[i] <= '0;
      end
    end else begin
      vq    <= {vq[1:0], in_valid_i};
      kq[0] <= op_i[2:0];
      nq[0] <= shamt_i[1:0];
      for (int i = 1; i < 3; i++) begin
        kq[i] <= kq[i-1];
        nq[i] <= nq[i-1];
      end
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign nb    = NAR_BASE << nq[2];
  assign res_x = (W+1)'($signed(result_o));
  assign hi_n  = ((W+1)'(1) <<< (nb - 1)) - (W+1)'(1);
  assign lo_n  = -((W+1)'(1) <<< (nb - 1));

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) |-> (out_valid_o == vq[2]));

  p_clamp_value_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && res_sat_o && kq[2] != 3'd7) |-> (result_o == MAXV || result_o == MINV));

  p_narrow_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3 && out_valid_o && kq[2] == 3'd7 && nb < W) |-> (res_x <= hi_n && res_x >= lo_n));

  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |=> sat_o);

  p_sticky_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_sat_o |-> sat_o);

  p_flag_qual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_sat_o |-> out_valid_o);
endmodule

bind fxp_mac_unit fxp_mac_unit_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .in_valid_i, .op_i, .shamt_i,
  .out_valid_o, .result_o, .res_sat_o, .sat_o
);

// File: tb/tb_fxp_mac_unit.sv
`timescale 1ns/1ps
module tb_fxp_mac_unit;
  localparam int W = 32;
  localparam int SW = $clog2(W);
  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [4:0]    op = '0;
  logic [W-1:0]  a = '0, b = '0, c = '0;
  logic [SW-1:0] sh = '0;
  logic          out_valid, res_sat, sat;
  logic [W-1:0]  result;

  int errors = 0, checks = 0;
  longint cyc = 0;

  fxp_mac_unit #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op),
    .a_i(a), .b_i(b), .c_i(c), .shamt_i(sh),
    .out_valid_o(out_valid), .result_o(result), .res_sat_o(res_sat), .sat_o(sat)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // expected results in issue order
  logic [W-1:0] e_res [$];
  logic         e_sat [$];
  longint       e_t   [$];
  string        e_tag [$];
  logic         e_sticky = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint rnd(input longint v, input int s);
    if (s == 0) return v;
    return (v + (64'sd1 <<< (s - 1))) >>> s;
  endfunction

  function automatic void ref_op(input logic [4:0] o, input logic [W-1:0] x, y, z,
                                 input int s, output logic [W-1:0] r, output logic st);
    longint xa, ya, za, ha, hb, v, hi, lo;
    int nb;
    xa = longint'($signed(x)); ya = longint'($signed(y)); za = longint'($signed(z));
    ha = o[3] ? longint'($signed(x[W-1:W/2])) : longint'($signed(x[W/2-1:0]));
    hb = o[4] ? longint'($signed(y[W-1:W/2])) : longint'($signed(y[W/2-1:0]));
    hi = MAXL; lo = MINL;
    case (o[2:0])
      3'd0: v = rnd(ha * hb, s);
      3'd1: v = za + rnd(ha * hb, s);
      3'd2: v = za - rnd(ha * hb, s);
      3'd3: v = xa + ya;
      3'd4: v = xa - ya;
      3'd5: v = rnd(xa, s);
      3'd6: v = xa <<< s;
      default: begin
        v = xa;
        nb = 8 << s[1:0];
        if (nb < W) begin
          hi = (64'sd1 <<< (nb - 1)) - 1;
          lo = -(64'sd1 <<< (nb - 1));
        end
      end
    endcase
    st = 1'b1;
    if (v > hi) v = hi;
    else if (v < lo) v = lo;
    else st = 1'b0;
    r = v[W-1:0];
  endfunction

  task automatic issue(input string tag, input logic [4:0] o, input logic [W-1:0] x, y, z,
                       input int s);
    logic [W-1:0] r; logic st;
    ref_op(o, x, y, z, s, r, st);
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; c = z; sh = SW'(s);
    e_res.push_back(r); e_sat.push_back(st); e_t.push_back(cyc + 3); e_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; op = $urandom; a = $urandom; b = $urandom; c = $urandom;
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (e_t.size() != 0 && e_t[0] == cyc) begin
        string t;
        logic [W-1:0] r; logic st;
        t = e_tag.pop_front(); r = e_res.pop_front(); st = e_sat.pop_front();
        void'(e_t.pop_front());
        e_sticky = e_sticky | st;
        chk({t, " R10 valid"}, longint'(out_valid), 1);
        chk({t, " result"}, longint'(result), longint'(r));
        chk({t, " R8 res_sat"}, longint'(res_sat), longint'(st));
        chk({t, " R9 sticky"}, longint'(sat), longint'(e_sticky));
      end else if (out_valid) begin
        chk("R10 spurious out_valid", 1, 0);
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 out_valid in reset", longint'(out_valid), 0);
    chk("R11 result in reset", longint'(result), 0);
    chk("R11 sat in reset", longint'(sat), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 half selection, R2 multiply
    issue("R1 lo*lo",  5'b00000, 32'h0003_FFFE, 32'h0005_0007, 0, 0);
    issue("R1 hi*lo",  5'b01000, 32'h0003_FFFE, 32'h0005_0007, 0, 0);
    issue("R1 lo*hi",  5'b10000, 32'h0003_FFFE, 32'h0005_0007, 0, 0);
    issue("R1 hi*hi",  5'b11000, 32'hFFFD_0000, 32'h0005_0000, 0, 0);
    issue("R2 mul min*min", 5'b00000, 32'h0000_8000, 32'h0000_8000, 0, 0);
    // R3 rounding half-up
    issue("R3 shr 5>>1",  5'd5, 32'd5, 0, 0, 1);
    issue("R3 shr -5>>1", 5'd5, 32'hFFFF_FFFB, 0, 0, 1);
    issue("R3 shr -6>>2", 5'd5, 32'hFFFF_FFFA, 0, 0, 2);
    issue("R3 shr s0",    5'd5, 32'h1234_5677, 0, 0, 0);
    issue("R3 mul rnd",   5'd0, 32'h0000_0007, 32'h0000_0003, 0, 2);
    idle(4);
    chk("R9 sticky low before clamp", longint'(sat), 0);
    // R4 multiply-add / sub
    issue("R4 maca", 5'b01001, 32'h4000_0000, 32'h0000_4000, 32'd100, 15);
    issue("R4 macs", 5'b00010, 32'h0000_0100, 32'h0000_0100, 32'd7, 4);
    issue("R4 maca rnd sat", 5'd1, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 1);
    issue("R4 maca at limit", 5'd1, 32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFE, 1);
    issue("R4 macs neg sat", 5'd2, 32'h0000_7FFF, 32'h0000_7FFF, 32'h8000_0000, 0);
    // R5
    issue("R5 add sat", 5'd3, 32'h7FFF_FFFF, 32'd1, 0, 0);
    issue("R5 sub sat", 5'd4, 32'h8000_0000, 32'd1, 0, 0);
    issue("R5 add ok",  5'd3, 32'hFFFF_FFF0, 32'd5, 0, 0);
    // R6
    issue("R6 shr max rnd", 5'd5, 32'h7FFF_FFFF, 0, 0, 1);
    issue("R6 shl ok",  5'd6, 32'h0000_0003, 0, 0, 4);
    issue("R6 shl sat", 5'd6, 32'h0001_0000, 0, 0, 16);
    issue("R6 shl neg sat", 5'd6, 32'hFFFF_0000, 0, 0, 17);
    // R7
    issue("R7 nar8 hi",  5'd7, 32'd300, 0, 0, 0);
    issue("R7 nar8 lo",  5'd7, 32'hFFFF_FF7F, 0, 0, 0);
    issue("R7 nar16",    5'd7, 32'hFFFE_0000, 0, 0, 1);
    issue("R7 nar32 pass", 5'd7, 32'h8000_0000, 0, 0, 2);
    issue("R7 nar64 pass", 5'd7, 32'h7FFF_FFFF, 0, 0, 3);
    idle(5);

    // random mix, back to back with occasional gaps
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] x, y, z;
      int pick;
      pick = $urandom_range(0, 7);
      x = (pick == 0) ? 32'h7FFF_FFFF : (pick == 1) ? 32'h8000_0000 : $urandom;
      y = $urandom;
      z = ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFF0 : $urandom;
      issue("R2 R4 R5 R6 R7 random", 5'($urandom), x, y, z, $urandom_range(0, W - 1));
      if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
    end
    idle(6);
    chk("R10 all results delivered", longint'(e_t.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule